// File: doc/BRIEF.md
# Display RAM Write Address Generator

This block turns a stream of display data-write strobes into write addresses for a monochrome display RAM. The RAM is organised as pages of bytes, one byte per column per page, and each byte holds a vertical strip of eight pixels. With the default parameters there are 128 columns and 8 pages, so the RAM holds 1024 bytes and the address is `page*128 + column`.

Three traversal orders are supported. Horizontal order walks columns first, then pages. Vertical order walks pages first, then columns. Both of these orders stay inside a programmable column window and page window. Page order walks columns along a single page, and it has its own start column, written as two nibbles. A command decoder upstream drives the load strobes. The RAM sits downstream and consumes `ramWe` and `ramAddr`.

Top module: `dispAddrGen`

## Requirements
- R1: After reset `ramWe` is 0 and `ramAddr` is 0. The mode is page order. The column window is 0..127 and the page window is 0..7. The page-order start column and page are 0, and both pointers are 0.
- R2: A `dataWrite` in a cycle with no load strobe sets `ramWe` to 1 in the next cycle. In that cycle `ramAddr` equals page*128+column of the pointers at the time of the write, and the pointers then advance. In any other cycle `ramWe` is 0 in the next cycle and `ramAddr` holds its value.
- R3: In horizontal order the column steps first. A write at the column window end moves the column to the window start and steps the page. A step from the page window end returns the page to the page window start.
- R4: In vertical order the page steps first. A write at the page window end moves the page to the page window start and steps the column, with the same column-window wrap as in R3.
- R5: In page order the column steps by one. After column 127 it returns to the page-order start column, and the page never changes.
- R6: `modeIn` code 00 selects horizontal order, 01 vertical and 10 page. A mode load moves the pointers to the new order's starts: the window starts for horizontal and vertical, and the page-order start column and page for page order.
- R7: A mode load with code 11 changes neither the mode nor the pointers.
- R8: A column or page window load stores both bounds. In horizontal or vertical order it also moves both pointers to the window starts. In page order it only stores the bounds.
- R9: In page order a command byte 0x00–0x0F sets the start-column low nibble and 0x10–0x1F sets the high nibble (start = high*16+low, taken modulo 128). Either of these also moves the column pointer to the new start. A byte 0xB0–0xB7 moves the page pointer to its low three bits. Any other byte, and any command outside page order, has no effect.
- R10: Only one strobe acts in a cycle. The priority order is mode load, column window load, page window load, page-order command, then data write. Any load strobe, even one that has no effect, suppresses the write in that cycle.
- R11: A window whose start exceeds its end counts upward modulo its range until it reaches the end value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLoad | input | 1 | Load traversal order from `modeIn` |
| modeIn | input | 2 | Order code: 00 horizontal, 01 vertical, 10 page, 11 ignored |
| colWinLoad | input | 1 | Load the column window |
| colStartIn | input | 7 | Column window start |
| colEndIn | input | 7 | Column window end |
| pageWinLoad | input | 1 | Load the page window |
| pageStartIn | input | 3 | Page window start |
| pageEndIn | input | 3 | Page window end |
| pmCmdLoad | input | 1 | Apply a page-order command byte |
| pmCmdIn | input | 8 | Page-order command byte |
| dataWrite | input | 1 | A data byte is being written |
| ramAddr | output | 10 | RAM write address, page*128+column |
| ramWe | output | 1 | RAM write enable |

## Verification
Two pointer wraps are hard to reach. One is the column wrap in vertical order, which needs a full page sweep for every column step. The other is the return from column 127 to a non-zero page-order start column, which needs well over a hundred writes after the start nibbles are set. The directed stimulus shrinks the windows to a few columns and pages so that several nested wraps happen within a few dozen writes. It places the page-order start near 127 so that the wrap comes quickly. A long random phase then mixes all strobes, including the invalid mode, reversed windows and simultaneous strobes, against a behavioural model that is compared on every clock.

// File: rtl/dagPkg.sv
package dagPkg;
  typedef enum logic [1:0] {
    MODE_HORZ = 2'b00,
    MODE_VERT = 2'b01,
    MODE_PAGE = 2'b10,
    MODE_BAD  = 2'b11
  } addrMode_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic      ldColWin;
    logic      ldPageWin;
    logic      ldPmLo;
    logic      ldPmHi;
    logic      ldPmPage;
    logic      colToWin;
    logic      pageToWin;
    logic      colToPm;
    logic      pageToPm;
    logic      advance;
    addrMode_e mode;
  } dagStrobe_t;
endpackage

// File: rtl/dagCtrl.sv
module dagCtrl
  import dagPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeLoad,
  input  logic [1:0] modeIn,
  input  logic       colWinLoad,
  input  logic       pageWinLoad,
  input  logic       pmCmdLoad,
  input  logic [7:0] pmCmdIn,
  input  logic       dataWrite,
  output dagStrobe_t strobe,
  output addrMode_e  curMode
);
  localparam logic [3:0] LO_NIB_OP = 4'h0;
  localparam logic [3:0] HI_NIB_OP = 4'h1;
  localparam logic [4:0] PAGE_OP   = 5'b10110;

  addrMode_e modeQ, modeNext;
  logic isLo, isHi, isPg;

  assign isLo = (pmCmdIn[7:4] == LO_NIB_OP);
  assign isHi = (pmCmdIn[7:4] == HI_NIB_OP);
  assign isPg = (pmCmdIn[7:3] == PAGE_OP);

  always_comb begin
    strobe = '0;
    strobe.mode = modeQ;
    modeNext = modeQ;
    if (modeLoad) begin
      if (addrMode_e'(modeIn) != MODE_BAD) begin
        modeNext = addrMode_e'(modeIn);
        if (modeNext == MODE_PAGE) begin
          strobe.colToPm  = 1'b1;
          strobe.pageToPm = 1'b1;
        end else begin
          strobe.colToWin  = 1'b1;
          strobe.pageToWin = 1'b1;
        end
      end
    end else if (colWinLoad) begin
      strobe.ldColWin = 1'b1;
      if (modeQ != MODE_PAGE) begin
        strobe.colToWin  = 1'b1;
        strobe.pageToWin = 1'b1;
      end
    end else if (pageWinLoad) begin
      strobe.ldPageWin = 1'b1;
      if (modeQ != MODE_PAGE) begin
        strobe.colToWin  = 1'b1;
        strobe.pageToWin = 1'b1;
      end
    end else if (pmCmdLoad) begin
      if (modeQ == MODE_PAGE) begin
        if (isLo) begin
          strobe.ldPmLo  = 1'b1;
          strobe.colToPm = 1'b1;
        end else if (isHi) begin
          strobe.ldPmHi  = 1'b1;
          strobe.colToPm = 1'b1;
        end else if (isPg) begin
          strobe.ldPmPage = 1'b1;
          strobe.pageToPm = 1'b1;
        end
      end
    end else if (dataWrite) begin
      strobe.advance = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_PAGE;
    else       modeQ <= modeNext;
  end

  assign curMode = modeQ;
endmodule

// File: rtl/dagPath.sv
module dagPath
  import dagPkg::*;
#(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int ADDR_W = $clog2(COLS * PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dagStrobe_t        strobe,
  input  logic [COL_W-1:0]  colStartIn,
  input  logic [COL_W-1:0]  colEndIn,
  input  logic [PAGE_W-1:0] pageStartIn,
  input  logic [PAGE_W-1:0] pageEndIn,
  input  logic [3:0]        pmNibble,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe
);
  localparam logic [COL_W-1:0]  COL_MAX  = COL_W'(COLS - 1);
  localparam logic [PAGE_W-1:0] PAGE_MAX = PAGE_W'(PAGES - 1);

  logic [COL_W-1:0]  colStartQ, colEndQ, colQ, colNext;
  logic [PAGE_W-1:0] pageStartQ, pageEndQ, pageQ, pageNext, pmPageQ;
  logic [3:0]        pmLoQ, pmHiQ;

  logic [COL_W-1:0]  colStartEff, pmStartCol, colWinStep;
  logic [PAGE_W-1:0] pageStartEff, pmPageEff, pageWinStep;
  logic [3:0]        pmLoEff, pmHiEff;
  logic [ADDR_W-1:0] addrNow;

  // Start values seen by pointer moves, including a load in this cycle
  assign colStartEff  = strobe.ldColWin  ? colStartIn  : colStartQ;
  assign pageStartEff = strobe.ldPageWin ? pageStartIn : pageStartQ;
  assign pmLoEff      = strobe.ldPmLo    ? pmNibble    : pmLoQ;
  assign pmHiEff      = strobe.ldPmHi    ? pmNibble    : pmHiQ;
  assign pmPageEff    = strobe.ldPmPage  ? PAGE_W'(pmNibble) : pmPageQ;
  assign pmStartCol   = COL_W'({pmHiEff, pmLoEff});

  // Single steps with window wrap
  assign colWinStep  = (colQ == colEndQ)   ? colStartQ  :
                       (colQ == COL_MAX)   ? '0 : colQ + 1'b1;
  assign pageWinStep = (pageQ == pageEndQ) ? pageStartQ :
                       (pageQ == PAGE_MAX) ? '0 : pageQ + 1'b1;

  always_comb begin
    colNext  = colQ;
    pageNext = pageQ;
    if (strobe.colToWin)  colNext  = colStartEff;
    if (strobe.pageToWin) pageNext = pageStartEff;
    if (strobe.colToPm)   colNext  = pmStartCol;
    if (strobe.pageToPm)  pageNext = pmPageEff;
    if (strobe.advance) begin
      unique case (strobe.mode)
        MODE_HORZ: begin
          colNext = colWinStep;
          if (colQ == colEndQ) pageNext = pageWinStep;
        end
        MODE_VERT: begin
          pageNext = pageWinStep;
          if (pageQ == pageEndQ) colNext = colWinStep;
        end
        default: begin
          colNext = (colQ == COL_MAX) ? pmStartCol : colQ + 1'b1;
        end
      endcase
    end
  end

  // Address composition: concatenation for power-of-two widths
  if ((1 << COL_W) == COLS) begin : gConcat
    assign addrNow = ADDR_W'({pageQ, colQ});
  end else begin : gMul
    assign addrNow = ADDR_W'(pageQ) * ADDR_W'(COLS) + ADDR_W'(colQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colStartQ  <= '0;
      colEndQ    <= COL_MAX;
      pageStartQ <= '0;
      pageEndQ   <= PAGE_MAX;
      pmLoQ      <= '0;
      pmHiQ      <= '0;
      pmPageQ    <= '0;
      colQ       <= '0;
      pageQ      <= '0;
      ramAddr    <= '0;
      ramWe      <= 1'b0;
    end else begin
      if (strobe.ldColWin) begin
        colStartQ <= colStartIn;
        colEndQ   <= colEndIn;
      end
      if (strobe.ldPageWin) begin
        pageStartQ <= pageStartIn;
        pageEndQ   <= pageEndIn;
      end
      pmLoQ   <= pmLoEff;
      pmHiQ   <= pmHiEff;
      pmPageQ <= pmPageEff;
      colQ    <= colNext;
      pageQ   <= pageNext;
      ramWe   <= strobe.advance;
      if (strobe.advance) ramAddr <= addrNow;
    end
  end
endmodule

// File: rtl/dispAddrGen.sv
module dispAddrGen
  import dagPkg::*;
#(
  parameter int COLS  = 128,
  parameter int PAGES = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             modeLoad,
  input  logic [1:0]                       modeIn,
  input  logic                             colWinLoad,
  input  logic [$clog2(COLS)-1:0]          colStartIn,
  input  logic [$clog2(COLS)-1:0]          colEndIn,
  input  logic                             pageWinLoad,
  input  logic [$clog2(PAGES)-1:0]         pageStartIn,
  input  logic [$clog2(PAGES)-1:0]         pageEndIn,
  input  logic                             pmCmdLoad,
  input  logic [7:0]                       pmCmdIn,
  input  logic                             dataWrite,
  output logic [$clog2(COLS*PAGES)-1:0]    ramAddr,
  output logic                             ramWe
);
  localparam int COL_W  = $clog2(COLS);
  localparam int ADDR_W = $clog2(COLS * PAGES);

  dagStrobe_t strobe;
  addrMode_e  curMode;

  dagCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeLoad    (modeLoad),
    .modeIn      (modeIn),
    .colWinLoad  (colWinLoad),
    .pageWinLoad (pageWinLoad),
    .pmCmdLoad   (pmCmdLoad),
    .pmCmdIn     (pmCmdIn),
    .dataWrite   (dataWrite),
    .strobe      (strobe),
    .curMode     (curMode)
  );

  dagPath #(.COLS(COLS), .PAGES(PAGES)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .colStartIn  (colStartIn),
    .colEndIn    (colEndIn),
    .pageStartIn (pageStartIn),
    .pageEndIn   (pageEndIn),
    .pmNibble    (pmCmdIn[3:0]),
    .ramAddr     (ramAddr),
    .ramWe       (ramWe)
  );
endmodule

// File: rtl/dagChecker.sv
module dagChecker
  import dagPkg::*;
#(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          modeLoad,
  input logic [1:0]    modeIn,
  input logic          colWinLoad,
  input logic          pageWinLoad,
  input logic          pmCmdLoad,
  input logic          dataWrite,
  input logic          ramWe,
  input logic [PW-1:0] pageField,
  input addrMode_e     curMode
);
  logic anyLoad;
  assign anyLoad = modeLoad | colWinLoad | pageWinLoad | pmCmdLoad;

  assert_write_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && !anyLoad) |=> ramWe);

  assert_load_blocks_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!dataWrite || anyLoad) |=> !ramWe);

  assert_bad_code_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeLoad && modeIn == 2'b11) |=> (curMode == $past(curMode)));

  assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    curMode != MODE_BAD);

  assert_page_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && $past(ramWe) && curMode == MODE_PAGE && $past(curMode) == MODE_PAGE)
      |-> (pageField == $past(pageField)));
endmodule

bind dispAddrGen dagChecker #(.PW(ADDR_W - COL_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .modeLoad    (modeLoad),
  .modeIn      (modeIn),
  .colWinLoad  (colWinLoad),
  .pageWinLoad (pageWinLoad),
  .pmCmdLoad   (pmCmdLoad),
  .dataWrite   (dataWrite),
  .ramWe       (ramWe),
  .pageField   (ramAddr[ADDR_W-1:COL_W]),
  .curMode     (curMode)
);

// File: tb/test_dispAddrGen.sv
`timescale 1ns/1ps
module test_dispAddrGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeLoad = 0, colWinLoad = 0, pageWinLoad = 0, pmCmdLoad = 0, dataWrite = 0;
  logic [1:0] modeIn = 0;
  logic [6:0] colStartIn = 0, colEndIn = 0;
  logic [2:0] pageStartIn = 0, pageEndIn = 0;
  logic [7:0] pmCmdIn = 0;
  logic [9:0] ramAddr;
  logic       ramWe;

  int    nCmp = 0, nBad = 0;
  bit    done = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  dispAddrGen i_dispAddrGen (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeIn(modeIn),
    .colWinLoad(colWinLoad), .colStartIn(colStartIn), .colEndIn(colEndIn),
    .pageWinLoad(pageWinLoad), .pageStartIn(pageStartIn), .pageEndIn(pageEndIn),
    .pmCmdLoad(pmCmdLoad), .pmCmdIn(pmCmdIn), .dataWrite(dataWrite),
    .ramAddr(ramAddr), .ramWe(ramWe)
  );

  // Behavioural reference model
  int mMode = 2, cs = 0, ce = 127, ps = 0, pe = 7;
  int pmLo = 0, pmHi = 0, pmPg = 0, col = 0, pg = 0, expAddr = 0;
  bit expWe = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 2; cs = 0; ce = 127; ps = 0; pe = 7;
      pmLo = 0; pmHi = 0; pmPg = 0; col = 0; pg = 0; expWe = 0; expAddr = 0;
    end else begin
      expWe = 0;
      if (modeLoad) begin
        if (modeIn != 3) begin
          mMode = modeIn;
          if (mMode == 2) begin col = (pmHi * 16 + pmLo) % 128; pg = pmPg; end
          else begin col = cs; pg = ps; end
        end
      end else if (colWinLoad) begin
        cs = colStartIn; ce = colEndIn;
        if (mMode != 2) begin col = cs; pg = ps; end
      end else if (pageWinLoad) begin
        ps = pageStartIn; pe = pageEndIn;
        if (mMode != 2) begin col = cs; pg = ps; end
      end else if (pmCmdLoad) begin
        if (mMode == 2) begin
          if (pmCmdIn < 16) begin pmLo = pmCmdIn; col = (pmHi * 16 + pmLo) % 128; end
          else if (pmCmdIn < 32) begin pmHi = pmCmdIn - 16; col = (pmHi * 16 + pmLo) % 128; end
          else if (pmCmdIn >= 8'hB0 && pmCmdIn <= 8'hB7) begin pmPg = pmCmdIn - 8'hB0; pg = pmPg; end
        end
      end else if (dataWrite) begin
        expWe = 1;
        expAddr = pg * 128 + col;
        if (mMode == 0) begin
          if (col == ce) begin col = cs; pg = (pg == pe) ? ps : (pg + 1) % 8; end
          else col = (col + 1) % 128;
        end else if (mMode == 1) begin
          if (pg == pe) begin pg = ps; col = (col == ce) ? cs : (col + 1) % 128; end
          else pg = (pg + 1) % 8;
        end else begin
          col = (col == 127) ? (pmHi * 16 + pmLo) % 128 : col + 1;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      nCmp++;
      if (ramWe !== expWe || ramAddr !== expAddr[9:0]) begin
        nBad++;
        $display("FAIL %s: ramWe=%0b ramAddr=%0d, expected ramWe=%0b ramAddr=%0d",
                 curReq, ramWe, ramAddr, expWe, expAddr);
      end
    end
  end

  task automatic clearAll();
    modeLoad = 0; colWinLoad = 0; pageWinLoad = 0; pmCmdLoad = 0; dataWrite = 0;
  endtask

  task automatic writes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clearAll(); dataWrite = 1;
    end
  endtask

  task automatic setMode(logic [1:0] m);
    @(negedge clk); clearAll(); modeLoad = 1; modeIn = m;
  endtask

  task automatic setCols(logic [6:0] s, logic [6:0] e);
    @(negedge clk); clearAll(); colWinLoad = 1; colStartIn = s; colEndIn = e;
  endtask

  task automatic setPages(logic [2:0] s, logic [2:0] e);
    @(negedge clk); clearAll(); pageWinLoad = 1; pageStartIn = s; pageEndIn = e;
  endtask

  task automatic pmCmd(logic [7:0] c);
    @(negedge clk); clearAll(); pmCmdLoad = 1; pmCmdIn = c;
  endtask

  task automatic finishRun();
    @(negedge clk); clearAll();
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    // R1, R5: page order from reset, column 127 wraps to start 0
    curReq = "R5"; writes(132);
    // R9: start column 0x75, then page 3; wrap back to 117
    curReq = "R9"; pmCmd(8'h05); pmCmd(8'h17); pmCmd(8'hB3);
    curReq = "R5"; writes(14);
    // R9: unrelated byte has no effect
    curReq = "R9"; pmCmd(8'h42); pmCmd(8'hB8); writes(3);
    // R6, R3: horizontal order over a small window
    curReq = "R6"; setMode(2'b00); writes(2);
    curReq = "R8"; setCols(7'd3, 7'd6); setPages(3'd2, 3'd4);
    curReq = "R3"; writes(30);
    // R7: invalid code ignored
    curReq = "R7"; setMode(2'b11); writes(3);
    // R9: page-order command ignored outside page order
    curReq = "R9"; pmCmd(8'hB6); pmCmd(8'h02); writes(3);
    // R4: vertical order with column wrap
    curReq = "R4"; setMode(2'b01); writes(30);
    // R11: reversed column window counts up modulo 128
    curReq = "R11"; setCols(7'd125, 7'd2); writes(20);
    // R10: simultaneous strobes
    curReq = "R10";
    @(negedge clk); clearAll(); dataWrite = 1; colWinLoad = 1; colStartIn = 10; colEndIn = 11;
    @(negedge clk); clearAll(); dataWrite = 1; modeLoad = 1; modeIn = 2'b00; pageWinLoad = 1;
    pageStartIn = 1; pageEndIn = 1;
    @(negedge clk); clearAll(); dataWrite = 1; pmCmdLoad = 1; pmCmdIn = 8'h00;
    writes(5);
    // R8: window load in page order stores only
    curReq = "R8"; setMode(2'b10); writes(2); setCols(7'd50, 7'd60); writes(3);
    setMode(2'b00); writes(12);
    // R2: random mix of all strobes
    curReq = "R2";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); clearAll();
      modeLoad    = ($urandom_range(0, 40) == 0);
      colWinLoad  = ($urandom_range(0, 40) == 0);
      pageWinLoad = ($urandom_range(0, 40) == 0);
      pmCmdLoad   = ($urandom_range(0, 15) == 0);
      dataWrite   = ($urandom_range(0, 3) != 0);
      modeIn      = 2'($urandom_range(0, 3));
      colStartIn  = 7'($urandom_range(0, 127));
      colEndIn    = 7'($urandom_range(0, 127));
      pageStartIn = 3'($urandom_range(0, 7));
      pageEndIn   = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: pmCmdIn = 8'($urandom_range(0, 31));
        1: pmCmdIn = 8'($urandom_range(8'hB0, 8'hB7));
        2: pmCmdIn = 8'($urandom_range(124, 127) % 16 + 16 * $urandom_range(0, 1));
        default: pmCmdIn = 8'($urandom_range(0, 255));
      endcase
    end
    finishRun();
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule